// File: doc/BRIEF.md
# Stream-to-Raster Video Output with Underflow Recovery

This block turns a packetised pixel stream with valid/ready handshaking into a clocked raster: a data-enable, horizontal and vertical syncs, and a pixel bus. A free-running timing generator sets the raster geometry from elaboration parameters. The raster side pulls pixels from an internal FIFO exactly when an active pixel is due, and the input ready follows the FIFO fill level. The downstream display therefore sets the pace of the whole upstream pipeline.

Each packet begins with a header beat whose low four data bits carry a type code. Code 0 marks a pixel packet and any other code marks a control packet. A frame start is a pixel-packet header that arrives directly after a control packet. After reset the block discards input until it sees a frame start. It then buffers that frame and begins showing it at the next raster frame boundary. If the FIFO is empty when an active pixel is due, or a pixel packet ends early, the block blanks the output and flushes the FIFO. It then drains the input with ready held high until the next frame start, and waits for the following boundary before showing pixels again. A sticky underflow flag records the event and stays set until software clears it through a small register port.

Top module: `stream_video_out`

## Requirements
- R1: While reset is held and in the first cycle after it, s_ready is 1, vid_de is 0, vid_data is the blank value, the syncs sit at their inactive level, and the sticky flag reads 0.
- R2: vid_hsync is active for H_SYNC cycles once every H_ACTIVE+H_FRONT+H_SYNC+H_BACK cycles. vid_vsync begins once every V_TOTAL lines (V_TOTAL = V_ACTIVE+V_FRONT+V_SYNC+V_BACK).
- R3: Only a header with type bits [3:0] equal to 0, arriving right after a header with a non-zero type, counts as a frame start. A pixel packet without a control packet before it is drained and never shown.
- R4: Pixels are shown in arrival order, only while the raster is in its active area. Each line's data-enable rises H_SYNC+H_BACK cycles after the rise of vid_hsync and lasts at most H_ACTIVE cycles. Display begins at the first active pixel of the raster frame after the frame start.
- R5: Once a frame is accepted, s_ready drops whenever the FIFO is full, and no accepted pixel is lost.
- R6: An active pixel slot that finds the FIFO empty is an underflow. vid_de stays 0, vid_data carries the blank value, and the sticky flag is set. In every cycle with vid_de low, vid_data equals the blank value.
- R7: After an underflow, s_ready stays 1 in every cycle and no pixel is shown until a new frame start (R3) and the following raster frame boundary.
- R8: A pixel packet whose end marker arrives before H_ACTIVE*V_ACTIVE pixels is handled exactly as an underflow, and its pixels are never shown.
- R9: The sticky flag reads as bit 0 at register address 0, and other addresses read 0. It holds until a write of 1 to address 0. Writes of 0, and writes to other addresses, leave it unchanged.
- R10: Pixels beyond H_ACTIVE*V_ACTIVE in one packet are discarded. Control packets that arrive between frames during display are ignored, so the next frame stays aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for stream, raster and registers |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input beat present |
| s_ready | output | 1 | Block accepts the beat this cycle |
| s_sop | input | 1 | Beat is a packet header |
| s_eop | input | 1 | Beat is the last of its packet |
| s_data | input | DW | Pixel, or type code in bits [3:0] on a header |
| vid_de | output | 1 | Active pixel on vid_data |
| vid_hsync | output | 1 | Line sync |
| vid_vsync | output | 1 | Frame sync |
| vid_data | output | DW | Output pixel, blank value when idle |
| reg_addr | input | REG_AW | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 1 | Write data; 1 at address 0 clears the flag |
| reg_rdata | output | 1 | Read data, combinational from reg_addr |

## Verification
Several frames are streamed with random gaps in valid. Bursts at full rate fill the FIFO during the wait for the boundary, which separates correct backpressure from lost or duplicated pixels. Letting the stream run dry creates a real underflow, which shows whether blanking, the sticky flag and continuous draining all start together. A pixel packet with no control packet before it, a short packet, and an over-long packet followed by a control packet and another frame check frame-start detection, the early-end rule and the trimming of extra pixels. Sync periods and the position of the data-enable are measured on every line against the raster geometry.

// File: rtl/vout_pkg.sv
package vout_pkg;

   typedef enum logic [1:0] {
      ST_WAIT_FRAME = 2'd0,
      ST_RUN        = 2'd1,
      ST_RESYNC     = 2'd2
   } vout_state_e;

   localparam int TYPE_W = 4;
   localparam logic [TYPE_W-1:0] PKT_PIXELS = '0;

   function automatic int unsigned span_total(input int unsigned a, input int unsigned b,
                                              input int unsigned c, input int unsigned d);
      return a + b + c + d;
   endfunction

endpackage

// File: rtl/vout_raster.sv
module vout_raster #(
   parameter int H_ACTIVE = 8,
   parameter int H_FRONT  = 2,
   parameter int H_SYNC   = 2,
   parameter int H_BACK   = 2,
   parameter int V_ACTIVE = 4,
   parameter int V_FRONT  = 1,
   parameter int V_SYNC   = 1,
   parameter int V_BACK   = 1
) (
   input  logic clk,
   input  logic rst,
   output logic pix_active,
   output logic hsync_raw,
   output logic vsync_raw,
   output logic frame_last
);
   localparam int H_TOTAL = vout_pkg::span_total(H_ACTIVE, H_FRONT, H_SYNC, H_BACK);
   localparam int V_TOTAL = vout_pkg::span_total(V_ACTIVE, V_FRONT, V_SYNC, V_BACK);
   localparam int HW = $clog2(H_TOTAL);
   localparam int VW = $clog2(V_TOTAL);
   localparam int HS_LO = H_ACTIVE + H_FRONT;
   localparam int HS_HI = HS_LO + H_SYNC;
   localparam int VS_LO = V_ACTIVE + V_FRONT;
   localparam int VS_HI = VS_LO + V_SYNC;

   logic [HW-1:0] h_q;
   logic [VW-1:0] v_q;
   logic          line_last;

   assign line_last = (h_q == HW'(H_TOTAL - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         h_q <= '0;
         v_q <= '0;
      end else if (line_last) begin
         h_q <= '0;
         v_q <= (v_q == VW'(V_TOTAL - 1)) ? '0 : v_q + 1'b1;
      end else begin
         h_q <= h_q + 1'b1;
      end
   end

   assign pix_active = (h_q < HW'(H_ACTIVE)) && (v_q < VW'(V_ACTIVE));
   assign hsync_raw  = (h_q >= HW'(HS_LO)) && (h_q < HW'(HS_HI));
   assign vsync_raw  = (v_q >= VW'(VS_LO)) && (v_q < VW'(VS_HI));
   assign frame_last = line_last && (v_q == VW'(V_TOTAL - 1));

endmodule

// File: rtl/vout_fifo.sv
module vout_fifo #(
   parameter int DW    = 24,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_depth_bad
      $error("vout_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wr_q, rd_q;

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_q[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
      end
   end

   assign rdata = mem[rd_q[AW-1:0]];
   assign empty = (wr_q == rd_q);
   assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);

endmodule

// File: rtl/vout_ctrl.sv
module vout_ctrl
   import vout_pkg::*;
#(
   parameter int FRAME_PIX = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s_valid,
   input  logic              s_sop,
   input  logic              s_eop,
   input  logic [TYPE_W-1:0] s_type,
   output logic              s_ready,
   input  logic              pix_active,
   input  logic              frame_last,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic              sticky_clr,
   output logic              fifo_push,
   output logic              fifo_pop,
   output logic              fifo_flush,
   output vout_state_e       state,
   output logic              sticky
);
   localparam int CW = $clog2(FRAME_PIX + 1);

   vout_state_e   state_q;
   logic          locked_q, ctrl_seen_q, in_pix_q, sticky_q;
   logic [CW-1:0] cnt_q;

   logic draining, storing, fire, hdr, hdr_pix, pix_beat, keep;
   logic frame_start, short_pkt, underrun, fault;

   assign draining = (state_q == ST_RESYNC) || (state_q == ST_WAIT_FRAME && !locked_q);
   assign storing  = (state_q == ST_RUN) || (state_q == ST_WAIT_FRAME && locked_q);
   assign s_ready  = draining || !fifo_full;
   assign fire     = s_valid && s_ready;
   assign hdr      = fire && s_sop;
   assign hdr_pix  = hdr && (s_type == PKT_PIXELS);
   assign pix_beat = fire && !s_sop && in_pix_q;
   assign keep     = pix_beat && storing && (cnt_q < CW'(FRAME_PIX));

   assign frame_start = hdr_pix && ctrl_seen_q && draining;
   assign short_pkt   = storing && fire && s_eop &&
                        ((hdr_pix) || (pix_beat && (cnt_q < CW'(FRAME_PIX - 1))));
   assign underrun    = (state_q == ST_RUN) && pix_active && fifo_empty;
   assign fault       = underrun || short_pkt;

   assign fifo_pop   = (state_q == ST_RUN) && pix_active && !fifo_empty;
   assign fifo_push  = keep && !fault;
   assign fifo_flush = fault;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_WAIT_FRAME;
         locked_q <= 1'b0;
      end else if (fault) begin
         state_q  <= ST_RESYNC;
         locked_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_WAIT_FRAME: begin
               if (frame_start) locked_q <= 1'b1;
               if (locked_q && frame_last) state_q <= ST_RUN;
            end
            ST_RESYNC: begin
               if (frame_start) begin
                  state_q  <= ST_WAIT_FRAME;
                  locked_q <= 1'b1;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_seen_q <= 1'b0;
         in_pix_q    <= 1'b0;
         cnt_q       <= '0;
      end else if (hdr) begin
         ctrl_seen_q <= (s_type != PKT_PIXELS);
         in_pix_q    <= (s_type == PKT_PIXELS) && !s_eop;
         cnt_q       <= '0;
      end else if (fire) begin
         if (s_eop) in_pix_q <= 1'b0;
         if (pix_beat && cnt_q < CW'(FRAME_PIX)) cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)             sticky_q <= 1'b0;
      else if (fault)      sticky_q <= 1'b1;
      else if (sticky_clr) sticky_q <= 1'b0;
   end

   assign state  = state_q;
   assign sticky = sticky_q;

endmodule

// File: rtl/stream_video_out.sv
module stream_video_out
   import vout_pkg::*;
#(
   parameter int          DW              = 24,
   parameter int          FIFO_DEPTH      = 16,
   parameter int          H_ACTIVE        = 8,
   parameter int          H_FRONT         = 2,
   parameter int          H_SYNC          = 2,
   parameter int          H_BACK          = 2,
   parameter int          V_ACTIVE        = 4,
   parameter int          V_FRONT         = 1,
   parameter int          V_SYNC          = 1,
   parameter int          V_BACK          = 1,
   parameter bit          SYNC_ACTIVE_LOW = 1'b0,
   parameter logic [DW-1:0] BLANK         = '0,
   parameter int          REG_AW          = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic              s_sop,
   input  logic              s_eop,
   input  logic [DW-1:0]     s_data,
   output logic              vid_de,
   output logic              vid_hsync,
   output logic              vid_vsync,
   output logic [DW-1:0]     vid_data,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_wdata,
   output logic              reg_rdata
);
   localparam int FRAME_PIX = H_ACTIVE * V_ACTIVE;

   if (DW < TYPE_W) begin : g_dw_bad
      $error("stream_video_out: DW must hold the packet type field");
   end
   if (H_ACTIVE < 1 || H_FRONT < 1 || H_SYNC < 1 || H_BACK < 1 ||
       V_ACTIVE < 1 || V_FRONT < 1 || V_SYNC < 1 || V_BACK < 1) begin : g_geom_bad
      $error("stream_video_out: every raster interval must be at least 1");
   end

   logic          pix_active, hsync_raw, vsync_raw, frame_last;
   logic          fifo_push, fifo_pop, fifo_flush, fifo_empty, fifo_full;
   logic [DW-1:0] fifo_rdata;
   logic          sticky, reg_clr;
   logic          hs_lvl, vs_lvl;
   vout_state_e   state;

   vout_raster #(
      .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
      .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
   ) u_raster (
      .clk(clk), .rst(rst), .pix_active(pix_active), .hsync_raw(hsync_raw),
      .vsync_raw(vsync_raw), .frame_last(frame_last)
   );

   vout_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .flush(fifo_flush), .push(fifo_push), .wdata(s_data),
      .pop(fifo_pop), .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full)
   );

   vout_ctrl #(.FRAME_PIX(FRAME_PIX)) u_ctrl (
      .clk(clk), .rst(rst), .s_valid(s_valid), .s_sop(s_sop), .s_eop(s_eop),
      .s_type(s_data[TYPE_W-1:0]), .s_ready(s_ready), .pix_active(pix_active),
      .frame_last(frame_last), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .sticky_clr(reg_clr), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
      .fifo_flush(fifo_flush), .state(state), .sticky(sticky)
   );

   if (SYNC_ACTIVE_LOW) begin : g_sync_low
      assign hs_lvl = ~hsync_raw;
      assign vs_lvl = ~vsync_raw;
   end else begin : g_sync_high
      assign hs_lvl = hsync_raw;
      assign vs_lvl = vsync_raw;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vid_de    <= 1'b0;
         vid_data  <= BLANK;
         vid_hsync <= SYNC_ACTIVE_LOW;
         vid_vsync <= SYNC_ACTIVE_LOW;
      end else begin
         vid_de    <= fifo_pop;
         vid_data  <= fifo_pop ? fifo_rdata : BLANK;
         vid_hsync <= hs_lvl;
         vid_vsync <= vs_lvl;
      end
   end

   assign reg_clr   = reg_wr && (reg_addr == '0) && reg_wdata;
   assign reg_rdata = (reg_addr == '0) && sticky;

endmodule

// File: rtl/stream_video_out_chk.sv
module stream_video_out_chk
   import vout_pkg::*;
#(
   parameter int            DW    = 24,
   parameter logic [DW-1:0] BLANK = '0
) (
   input logic          clk,
   input logic          rst,
   input vout_state_e   state,
   input logic          sticky,
   input logic          reg_clr,
   input logic          s_ready,
   input logic          fifo_push,
   input logic          fifo_full,
   input logic          fifo_empty,
   input logic          pix_active,
   input logic          vid_de,
   input logic [DW-1:0] vid_data
);

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      fifo_push |-> !fifo_full);

   assert_resync_drain_R7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RESYNC) |-> s_ready);

   assert_blank_fill_R6: assert property (@(posedge clk) disable iff (rst)
      !vid_de |-> (vid_data == BLANK));

   assert_underflow_enter_R6: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RUN && pix_active && fifo_empty) |=> (state == ST_RESYNC && sticky));

   assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (sticky && !reg_clr) |=> sticky);

   assert_de_in_run_R4: assert property (@(posedge clk) disable iff (rst)
      vid_de |-> ($past(state) == ST_RUN));

   assert_no_skip_R3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RESYNC) |=> (state != ST_RUN));

endmodule

bind stream_video_out stream_video_out_chk #(.DW(DW), .BLANK(BLANK)) u_chk (
   .clk(clk), .rst(rst), .state(state), .sticky(sticky), .reg_clr(reg_clr),
   .s_ready(s_ready), .fifo_push(fifo_push), .fifo_full(fifo_full),
   .fifo_empty(fifo_empty), .pix_active(pix_active), .vid_de(vid_de),
   .vid_data(vid_data)
);

// File: tb/stream_video_out_bench.sv
module stream_video_out_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 24;
   localparam int HA = 8, HF = 2, HS = 2, HB = 2;
   localparam int VA = 4, VF = 1, VS = 1, VB = 1;
   localparam int HT = HA + HF + HS + HB;
   localparam int VT = VA + VF + VS + VB;
   localparam int FPIX = HA * VA;

   logic clk = 1'b0, rst = 1'b1;
   logic s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
   logic [DW-1:0] s_data = '0;
   logic s_ready, vid_de, vid_hsync, vid_vsync, reg_rdata;
   logic [DW-1:0] vid_data;
   logic [1:0] reg_addr = '0;
   logic reg_wr = 1'b0, reg_wdata = 1'b0;

   int tests = 0, fails = 0;
   int valid_pct = 100;
   logic [DW+1:0] src_q[$];
   logic [DW-1:0] exp_q[$];
   int de_total = 0, seen_total = 0, nrdy_cycles = 0, bp_cycles = 0;
   bit mon_en = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stream_video_out u_stream_video_out (
      .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_sop(s_sop),
      .s_eop(s_eop), .s_data(s_data), .vid_de(vid_de), .vid_hsync(vid_hsync),
      .vid_vsync(vid_vsync), .vid_data(vid_data), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pix_val(input int f, input int i);
      return DW'((f << 8) | i);
   endfunction

   task automatic send_ctrl();
      src_q.push_back({1'b1, 1'b1, DW'(5)});
   endtask

   task automatic send_frame(input int f, input int n, input bit show);
      src_q.push_back({1'b1, 1'b0, DW'(0)});
      for (int i = 0; i < n; i++) begin
         src_q.push_back({1'b0, (i == n - 1), pix_val(f, i)});
         if (show && i < FPIX) exp_q.push_back(pix_val(f, i));
      end
   endtask

   task automatic frame_sync();
      do @(negedge clk); while (!vid_vsync);
      do @(negedge clk); while (vid_vsync);
      repeat (HT + 2) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_addr = '0; reg_wdata = 1'b0;
   endtask

   task automatic wait_drained(input int limit);
      for (int i = 0; i < limit && exp_q.size() > 0; i++) @(negedge clk);
   endtask

   // stream source
   initial begin
      bit fire;
      @(negedge rst);
      forever begin
         @(negedge clk);
         fire = s_valid && s_ready;
         @(posedge clk); #1;
         if (fire) void'(src_q.pop_front());
         if (src_q.size() > 0 && $urandom_range(99, 0) < valid_pct) begin
            s_valid = 1'b1;
            {s_sop, s_eop, s_data} = src_q[0];
         end else begin
            s_valid = 1'b0;
         end
      end
   end

   // output monitor
   initial begin
      logic hs_p = 1'b0, vs_p = 1'b0, de_p = 1'b0;
      int hs_cnt = 0, vs_cnt = 0, hs_w = 0, de_run = 0;
      bit hs_seen = 1'b0, vs_seen = 1'b0;
      forever begin
         @(negedge clk);
         if (mon_en) begin
            if (!s_ready) nrdy_cycles++;
            if (s_valid && !s_ready) bp_cycles++;
            if (vid_hsync && !hs_p) begin
               if (hs_seen) check(hs_cnt + 1 == HT, "R2 hsync period", hs_cnt + 1, HT);
               hs_seen = 1'b1; hs_cnt = 0; hs_w = 0;
            end else hs_cnt++;
            if (vid_hsync) hs_w++;
            if (!vid_hsync && hs_p) check(hs_w == HS, "R2 hsync width", hs_w, HS);
            if (vid_vsync && !vs_p) begin
               if (vs_seen) check(vs_cnt + 1 == HT * VT, "R2 vsync period", vs_cnt + 1, HT * VT);
               vs_seen = 1'b1; vs_cnt = 0;
            end else vs_cnt++;
            if (vid_de && !de_p) check(hs_cnt == HS + HB, "R4 de offset from hsync", hs_cnt, HS + HB);
            de_run = vid_de ? de_run + 1 : 0;
            if (vid_de) check(de_run <= HA, "R4 de run length", de_run, HA);
            if (!vid_de) check(vid_data == '0, "R6 blank value", vid_data, 0);
            if (vid_de) begin
               de_total++;
               if (exp_q.size() == 0) check(1'b0, "R4 unexpected pixel", vid_data, 0);
               else begin
                  logic [DW-1:0] e;
                  e = exp_q.pop_front();
                  check(vid_data == e, "R4/R10 pixel order", vid_data, e);
                  seen_total++;
               end
            end
         end
         hs_p = vid_hsync; vs_p = vid_vsync; de_p = vid_de;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int d0, s0, n0;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(s_ready == 1'b1, "R1 ready in reset", s_ready, 1);
      check(vid_de == 1'b0, "R1 de in reset", vid_de, 0);
      #1 rst = 1'b0;
      @(negedge clk);
      check(s_ready == 1'b1, "R1 ready after reset", s_ready, 1);
      check(vid_de == 1'b0, "R1 de after reset", vid_de, 0);
      check(vid_hsync == 1'b0 && vid_vsync == 1'b0, "R1 syncs inactive", {vid_hsync, vid_vsync}, 0);
      check(vid_data == '0, "R1 blank data", vid_data, 0);
      check(reg_rdata == 1'b0, "R1 sticky clear", reg_rdata, 0);
      mon_en = 1'b1;

      // R3: pixel packet without control is drained, never shown
      d0 = de_total;
      send_frame(9, FPIX, 1'b0);
      repeat (FPIX + 6) @(negedge clk);
      check(src_q.size() == 0, "R3 lone packet drained", src_q.size(), 0);
      repeat (2 * HT * VT) @(negedge clk);
      check(de_total == d0, "R3 lone packet not shown", de_total - d0, 0);

      // R4/R5: three frames with random gaps
      valid_pct = 75;
      frame_sync();
      s0 = seen_total; n0 = bp_cycles;
      send_ctrl();
      for (int f = 1; f <= 3; f++) send_frame(f, FPIX, 1'b1);
      wait_drained(6 * HT * VT);
      check(seen_total - s0 == 3 * FPIX, "R4 all pixels shown", seen_total - s0, 3 * FPIX);
      check(bp_cycles > n0, "R5 backpressure seen", bp_cycles - n0, 1);
      repeat (2) @(negedge clk);
      check(reg_rdata == 1'b0, "R6 no underflow while fed", reg_rdata, 0);

      // R6/R7: stream runs dry, underflow, then continuous drain
      repeat (2 * HT * VT) @(negedge clk);
      check(reg_rdata == 1'b1, "R6 sticky after underflow", reg_rdata, 1);
      d0 = de_total; n0 = nrdy_cycles;
      valid_pct = 100;
      send_frame(7, 20, 1'b0);
      repeat (2 * HT * VT) @(negedge clk);
      check(nrdy_cycles == n0, "R7 ready held in resync", nrdy_cycles - n0, 0);
      check(src_q.size() == 0, "R7 input drained", src_q.size(), 0);
      check(de_total == d0, "R7 nothing shown in resync", de_total - d0, 0);

      // R9: register port
      reg_write(2'd1, 1'b1);
      @(negedge clk);
      check(reg_rdata == 1'b1, "R9 write other address ignored", reg_rdata, 1);
      reg_write(2'd0, 1'b0);
      @(negedge clk);
      check(reg_rdata == 1'b1, "R9 write zero ignored", reg_rdata, 1);
      reg_addr = 2'd1; #1;
      check(reg_rdata == 1'b0, "R9 other address reads zero", reg_rdata, 0);
      reg_addr = 2'd0;
      reg_write(2'd0, 1'b1);
      @(negedge clk);
      check(reg_rdata == 1'b0, "R9 write one clears", reg_rdata, 0);

      // R8: short packet
      frame_sync();
      d0 = de_total;
      send_ctrl();
      send_frame(4, FPIX - 22, 1'b0);
      repeat (3 * HT * VT) @(negedge clk);
      check(reg_rdata == 1'b1, "R8 short packet sets sticky", reg_rdata, 1);
      check(de_total == d0, "R8 short packet not shown", de_total - d0, 0);
      reg_write(2'd0, 1'b1);
      @(negedge clk);
      check(reg_rdata == 1'b0, "R9 clear again", reg_rdata, 0);

      // R10: over-long packet, control in between, next frame aligned
      valid_pct = 85;
      frame_sync();
      s0 = seen_total;
      send_ctrl();
      send_frame(5, FPIX + 3, 1'b1);
      send_ctrl();
      send_frame(6, FPIX, 1'b1);
      wait_drained(5 * HT * VT);
      check(seen_total - s0 == 2 * FPIX, "R10 trimmed frames shown", seen_total - s0, 2 * FPIX);
      repeat (2) @(negedge clk);
      check(reg_rdata == 1'b0, "R10 no underflow across frames", reg_rdata, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule